// File: doc/BRIEF.md
# Dual-Slot Reservation Station with Class Priority

This block buffers operations waiting for one ALU of an out-of-order core. It has two single-entry slots. The priority slot holds one operation of a special class, and the general slot holds one ordinary register operation. A parameter fixes the special class. In the branch variant it is conditional branches, and the special result is a taken/not-taken decision for instruction fetch. In the memory variant it is loads and stores, and the special result is an effective address for the data memory path.

Dispatch logic loads a slot only while that slot reports that it can accept. Each cycle the ALU takes the priority slot if it holds an operation, and otherwise the general slot. The chosen operation is evaluated and its slot is freed in the same clock edge. The result appears on a registered output for one cycle. General results go on the writeback bus as a destination pointer and a 16-bit value. Special results go on the side channel only.

Top module: `dual_slot_rs`

## Requirements
- R1: After a synchronous active-low reset, both ready outputs are 1 and `wb_valid` and `side_valid` are 0.
- R2: A slot's ready output is 1 exactly when the slot is empty. A load pulse while the slot is ready stores the operation. A load pulse while the slot is full is ignored: the stored operation and its later result are unchanged, and no extra result is produced.
- R3: When both slots are valid, the special operation executes first and the general one executes on the next cycle.
- R4: Exactly one stored operation executes per cycle while any slot is valid. Executing frees its slot at the same clock edge that registers its result. Each operation produces exactly one output cycle, and `wb_valid` and `side_valid` are never both 1.
- R5: A general operation drives `wb_dst` and `wb_data` for the following opcodes, with the immediate sign-extended from 12 to 16 bits and all arithmetic modulo 2^16: 0 = src1+src2, 1 = src1-src2, 2 = AND, 3 = OR, 4 = immediate, 5 = XOR, 6 = src1+immediate. Any other opcode gives 0.
- R6: Branch variant: `side_flag` is 1 for opcode 8 when src1 equals src2, and 1 for opcode 9 when they differ. Every other case gives 0. `side_addr` carries the sign-extended immediate (the branch offset). A special operation never asserts `wb_valid`.
- R7: Memory variant: `side_addr` is src1 plus the sign-extended immediate, modulo 2^16. `side_flag` is 1 for opcode 11 (store) and 0 for any other opcode (load).
- R8: For an operation loaded into an otherwise idle station, the result is valid in the cycle after the second rising edge counted from the load edge. `side_dst` or `wb_dst` carries its destination pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spc_load | input | 1 | Load pulse for the priority slot |
| spc_op | input | 4 | Priority operation opcode |
| spc_dst | input | 4 | Priority operation destination pointer |
| spc_src1 | input | 16 | Priority operation source 1 |
| spc_src2 | input | 16 | Priority operation source 2 |
| spc_imm | input | 12 | Priority operation immediate |
| spc_ready | output | 1 | Priority slot empty |
| gen_load | input | 1 | Load pulse for the general slot |
| gen_op | input | 4 | General operation opcode |
| gen_dst | input | 4 | General operation destination pointer |
| gen_src1 | input | 16 | General operation source 1 |
| gen_src2 | input | 16 | General operation source 2 |
| gen_imm | input | 12 | General operation immediate |
| gen_ready | output | 1 | General slot empty |
| wb_valid | output | 1 | Writeback bus carries a result |
| wb_dst | output | 4 | Writeback destination pointer |
| wb_data | output | 16 | Writeback result |
| side_valid | output | 1 | Side channel carries a special result |
| side_dst | output | 4 | Destination pointer of the special operation |
| side_flag | output | 1 | Branch taken, or store indicator |
| side_addr | output | 16 | Branch offset or memory address |

## Verification
On every cycle, the assertions check the following:
- a priority slot that is valid yields a side result on the next cycle;
- a general slot that is alone yields a writeback on the next cycle;
- the two outputs never fire together;
- executing frees the slot;
- a full slot keeps its contents.

Only the bench scenarios can show that the computed values are correct. It sweeps every opcode over many operand pairs on both variants, covering equal and unequal branch operands, negative immediates and address wrap. They also show that a load into a full slot leaves no trace at the outputs and that the result latency is as stated.

// File: rtl/rs_pkg.sv
// Shared definitions for the dual-slot reservation station.
// Assumes 4-bit opcodes; encodings below are the station's contract with dispatch.
package rs_pkg;
    typedef enum logic {
        KIND_BRANCH = 1'b0,
        KIND_MEMORY = 1'b1
    } rs_kind_e;

    localparam logic [3:0] OP_ADD  = 4'd0;
    localparam logic [3:0] OP_SUB  = 4'd1;
    localparam logic [3:0] OP_AND  = 4'd2;
    localparam logic [3:0] OP_OR   = 4'd3;
    localparam logic [3:0] OP_MOVI = 4'd4;
    localparam logic [3:0] OP_XOR  = 4'd5;
    localparam logic [3:0] OP_ADDI = 4'd6;
    localparam logic [3:0] OP_BEQ  = 4'd8;
    localparam logic [3:0] OP_BNE  = 4'd9;
    localparam logic [3:0] OP_STORE = 4'd11;
endpackage

// File: rtl/rs_slot.sv
// Single-entry operation slot.
// Holds a packed payload and a valid bit. It accepts a load only while empty,
// and it empties when the selector takes it. Assumes take is only raised while valid.
module rs_slot #(
    parameter int PAY_W = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PAY_W-1:0] pay_in,
    input  logic             take,
    output logic             valid,
    output logic [PAY_W-1:0] pay_q
);
    // Purpose: track occupancy and capture the payload on an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            pay_q <= '0;
        end else if (take) begin
            valid <= 1'b0;
        end else if (load && !valid) begin
            valid <= 1'b1;
            pay_q <= pay_in;
        end
    end

    // R4: a taken slot is empty afterwards
    p_take_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !valid);

    // R2: a full slot that is not taken keeps its contents
    p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !take) |=> (valid && $stable(pay_q)));
endmodule

// File: rtl/rs_pick.sv
// Fixed-priority selector: the special slot wins over the general slot.
// Assumes both valid inputs come straight from the slot registers.
module rs_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic spc_valid,
    input  logic gen_valid,
    output logic take_spc,
    output logic take_gen
);
    // Purpose: grant at most one slot per cycle, priority slot first.
    always_comb begin
        take_spc = spc_valid;
        take_gen = gen_valid && !spc_valid;
    end

    // R4: at most one grant per cycle
    p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_spc, take_gen}));
endmodule

// File: rtl/rs_alu.sv
// Combinational evaluation for both slots of a station.
// The general path covers a small register-operation set. The special path
// computes both the branch and the memory result, and SPC_KIND picks which one
// leaves. Assumes the immediate is two's complement.
module rs_alu #(
    parameter int              DATA_W   = 16,
    parameter int              IMM_W    = 12,
    parameter int              OP_W     = 4,
    parameter rs_pkg::rs_kind_e SPC_KIND = rs_pkg::KIND_BRANCH
) (
    input  logic [OP_W-1:0]   g_op,
    input  logic [DATA_W-1:0] g_a,
    input  logic [DATA_W-1:0] g_b,
    input  logic [IMM_W-1:0]  g_imm,
    input  logic [OP_W-1:0]   s_op,
    input  logic [DATA_W-1:0] s_a,
    input  logic [DATA_W-1:0] s_b,
    input  logic [IMM_W-1:0]  s_imm,
    output logic [DATA_W-1:0] g_res,
    output logic              s_flag,
    output logic [DATA_W-1:0] s_addr
);
    import rs_pkg::*;

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] g_ext;
    logic [DATA_W-1:0] s_ext;
    logic              br_taken;
    logic              mem_store;
    logic [DATA_W-1:0] mem_addr;

    // Purpose: sign-extend both immediates.
    always_comb begin
        g_ext = {{EXT_W{g_imm[IMM_W-1]}}, g_imm};
        s_ext = {{EXT_W{s_imm[IMM_W-1]}}, s_imm};
    end

    // Purpose: general register-operation result.
    always_comb begin
        case (g_op)
            OP_ADD:  g_res = g_a + g_b;
            OP_SUB:  g_res = g_a - g_b;
            OP_AND:  g_res = g_a & g_b;
            OP_OR:   g_res = g_a | g_b;
            OP_MOVI: g_res = g_ext;
            OP_XOR:  g_res = g_a ^ g_b;
            OP_ADDI: g_res = g_a + g_ext;
            default: g_res = '0;
        endcase
    end

    // Purpose: branch decision and memory address candidates.
    always_comb begin
        br_taken  = ((s_op == OP_BEQ) && (s_a == s_b)) ||
                    ((s_op == OP_BNE) && (s_a != s_b));
        mem_store = (s_op == OP_STORE);
        mem_addr  = s_a + s_ext;
    end

    // Purpose: route the variant chosen by SPC_KIND to the side result.
    generate
        if (SPC_KIND == KIND_MEMORY) begin : g_mem
            always_comb begin
                s_flag = mem_store;
                s_addr = mem_addr;
            end
        end else begin : g_br
            logic unused_mem;
            always_comb begin
                s_flag     = br_taken;
                s_addr     = s_ext;
                unused_mem = mem_store ^ (^mem_addr);
            end
        end
    endgenerate
endmodule

// File: rtl/dual_slot_rs.sv
// Reservation station with a priority slot and a general slot feeding one ALU.
// Each cycle it executes the priority operation if present, otherwise the general
// one. Results are registered: general results go to the writeback bus, special
// results to the side channel. Assumes dispatch loads a slot only while its ready
// output is high; loads at other times are dropped.
module dual_slot_rs #(
    parameter int               DATA_W   = 16,
    parameter int               IMM_W    = 12,
    parameter int               OP_W     = 4,
    parameter int               PTR_W    = 4,
    parameter rs_pkg::rs_kind_e SPC_KIND = rs_pkg::KIND_BRANCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spc_load,
    input  logic [OP_W-1:0]   spc_op,
    input  logic [PTR_W-1:0]  spc_dst,
    input  logic [DATA_W-1:0] spc_src1,
    input  logic [DATA_W-1:0] spc_src2,
    input  logic [IMM_W-1:0]  spc_imm,
    output logic              spc_ready,
    input  logic              gen_load,
    input  logic [OP_W-1:0]   gen_op,
    input  logic [PTR_W-1:0]  gen_dst,
    input  logic [DATA_W-1:0] gen_src1,
    input  logic [DATA_W-1:0] gen_src2,
    input  logic [IMM_W-1:0]  gen_imm,
    output logic              gen_ready,
    output logic              wb_valid,
    output logic [PTR_W-1:0]  wb_dst,
    output logic [DATA_W-1:0] wb_data,
    output logic              side_valid,
    output logic [PTR_W-1:0]  side_dst,
    output logic              side_flag,
    output logic [DATA_W-1:0] side_addr
);
    localparam int IMM_LO = 0;
    localparam int SRC2_LO = IMM_LO + IMM_W;
    localparam int SRC1_LO = SRC2_LO + DATA_W;
    localparam int DST_LO = SRC1_LO + DATA_W;
    localparam int OP_LO  = DST_LO + PTR_W;
    localparam int PAY_W  = OP_LO + OP_W;

    logic [PAY_W-1:0] spc_pay_in, gen_pay_in, spc_pay, gen_pay;
    logic             spc_valid, gen_valid, take_spc, take_gen;
    logic [DATA_W-1:0] g_res, s_addr;
    logic              s_flag;

    // Purpose: pack the dispatch fields into slot payloads.
    always_comb begin
        spc_pay_in = {spc_op, spc_dst, spc_src1, spc_src2, spc_imm};
        gen_pay_in = {gen_op, gen_dst, gen_src1, gen_src2, gen_imm};
    end

    rs_slot #(.PAY_W(PAY_W)) u_spc_slot (
        .clk(clk), .rst_n(rst_n), .load(spc_load), .pay_in(spc_pay_in),
        .take(take_spc), .valid(spc_valid), .pay_q(spc_pay)
    );

    rs_slot #(.PAY_W(PAY_W)) u_gen_slot (
        .clk(clk), .rst_n(rst_n), .load(gen_load), .pay_in(gen_pay_in),
        .take(take_gen), .valid(gen_valid), .pay_q(gen_pay)
    );

    rs_pick u_pick (
        .clk(clk), .rst_n(rst_n), .spc_valid(spc_valid), .gen_valid(gen_valid),
        .take_spc(take_spc), .take_gen(take_gen)
    );

    rs_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W), .OP_W(OP_W), .SPC_KIND(SPC_KIND)) u_alu (
        .g_op (gen_pay[OP_LO +: OP_W]),
        .g_a  (gen_pay[SRC1_LO +: DATA_W]),
        .g_b  (gen_pay[SRC2_LO +: DATA_W]),
        .g_imm(gen_pay[IMM_LO +: IMM_W]),
        .s_op (spc_pay[OP_LO +: OP_W]),
        .s_a  (spc_pay[SRC1_LO +: DATA_W]),
        .s_b  (spc_pay[SRC2_LO +: DATA_W]),
        .s_imm(spc_pay[IMM_LO +: IMM_W]),
        .g_res(g_res), .s_flag(s_flag), .s_addr(s_addr)
    );

    // Purpose: slot availability for dispatch.
    always_comb begin
        spc_ready = !spc_valid;
        gen_ready = !gen_valid;
    end

    // Purpose: register the writeback bus and the side channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid   <= 1'b0;
            wb_dst     <= '0;
            wb_data    <= '0;
            side_valid <= 1'b0;
            side_dst   <= '0;
            side_flag  <= 1'b0;
            side_addr  <= '0;
        end else begin
            wb_valid   <= take_gen;
            side_valid <= take_spc;
            if (take_gen) begin
                wb_dst  <= gen_pay[DST_LO +: PTR_W];
                wb_data <= g_res;
            end
            if (take_spc) begin
                side_dst  <= spc_pay[DST_LO +: PTR_W];
                side_flag <= s_flag;
                side_addr <= s_addr;
            end
        end
    end

    // R3: a waiting priority operation always produces the next side result
    p_spc_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        spc_valid |=> side_valid);

    // R3: a general operation alone produces the next writeback
    p_gen_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_valid && !spc_valid) |=> wb_valid);

    // R4: never two results in one cycle
    p_single_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && side_valid));
endmodule

// File: tb/dual_slot_rs_bench.sv
// Bench: drives a branch-variant and a memory-variant station with the same stimulus.
module dual_slot_rs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spc_load = 1'b0, gen_load = 1'b0;
    logic [3:0]  spc_op = '0, gen_op = '0, spc_dst = '0, gen_dst = '0;
    logic [15:0] spc_src1 = '0, spc_src2 = '0, gen_src1 = '0, gen_src2 = '0;
    logic [11:0] spc_imm = '0, gen_imm = '0;

    logic        b_spc_ready, b_gen_ready, b_wb_valid, b_side_valid, b_side_flag;
    logic [3:0]  b_wb_dst, b_side_dst;
    logic [15:0] b_wb_data, b_side_addr;
    logic        m_spc_ready, m_gen_ready, m_wb_valid, m_side_valid, m_side_flag;
    logic [3:0]  m_wb_dst, m_side_dst;
    logic [15:0] m_wb_data, m_side_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_slot_rs #(.SPC_KIND(rs_pkg::KIND_BRANCH)) u_dual_slot_rs (
        .clk(clk), .rst_n(rst_n),
        .spc_load(spc_load), .spc_op(spc_op), .spc_dst(spc_dst), .spc_src1(spc_src1),
        .spc_src2(spc_src2), .spc_imm(spc_imm), .spc_ready(b_spc_ready),
        .gen_load(gen_load), .gen_op(gen_op), .gen_dst(gen_dst), .gen_src1(gen_src1),
        .gen_src2(gen_src2), .gen_imm(gen_imm), .gen_ready(b_gen_ready),
        .wb_valid(b_wb_valid), .wb_dst(b_wb_dst), .wb_data(b_wb_data),
        .side_valid(b_side_valid), .side_dst(b_side_dst), .side_flag(b_side_flag),
        .side_addr(b_side_addr)
    );

    dual_slot_rs #(.SPC_KIND(rs_pkg::KIND_MEMORY)) u_dual_slot_rs_mem (
        .clk(clk), .rst_n(rst_n),
        .spc_load(spc_load), .spc_op(spc_op), .spc_dst(spc_dst), .spc_src1(spc_src1),
        .spc_src2(spc_src2), .spc_imm(spc_imm), .spc_ready(m_spc_ready),
        .gen_load(gen_load), .gen_op(gen_op), .gen_dst(gen_dst), .gen_src1(gen_src1),
        .gen_src2(gen_src2), .gen_imm(gen_imm), .gen_ready(m_gen_ready),
        .wb_valid(m_wb_valid), .wb_dst(m_wb_dst), .wb_data(m_wb_data),
        .side_valid(m_side_valid), .side_dst(m_side_dst), .side_flag(m_side_flag),
        .side_addr(m_side_addr)
    );

    // Purpose: end a hung run as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sx(input logic [11:0] v);
        return {{4{v[11]}}, v};
    endfunction

    function automatic logic [15:0] gen_model(input logic [3:0] op, input logic [15:0] a,
                                              input logic [15:0] b, input logic [11:0] i);
        case (op)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return sx(i);
            4'd5: return a ^ b;
            4'd6: return a + sx(i);
            default: return 16'h0;
        endcase
    endfunction

    // R5, R8: one general operation on an idle station
    task automatic run_gen(input logic [3:0] op, input logic [3:0] d, input logic [15:0] a,
                           input logic [15:0] b, input logic [11:0] i);
        gen_op = op; gen_dst = d; gen_src1 = a; gen_src2 = b; gen_imm = i; gen_load = 1'b1;
        @(negedge clk);
        gen_load = 1'b0;
        chk({b_wb_valid, b_gen_ready}, 2'b00, "R8 no result one edge after load");
        @(negedge clk);
        chk({b_wb_valid, m_wb_valid, b_side_valid, m_side_valid}, 4'b1100, "R5 wb only");
        chk({b_wb_dst, b_wb_data}, {d, gen_model(op, a, b, i)}, "R5 branch-variant wb");
        chk({m_wb_dst, m_wb_data}, {d, gen_model(op, a, b, i)}, "R5 memory-variant wb");
    endtask

    // R6, R7, R8: one special operation on an idle station
    task automatic run_spc(input logic [3:0] op, input logic [3:0] d, input logic [15:0] a,
                           input logic [15:0] b, input logic [11:0] i);
        logic taken;
        taken = ((op == 4'd8) && (a == b)) || ((op == 4'd9) && (a != b));
        spc_op = op; spc_dst = d; spc_src1 = a; spc_src2 = b; spc_imm = i; spc_load = 1'b1;
        @(negedge clk);
        spc_load = 1'b0;
        chk({b_side_valid, b_spc_ready}, 2'b00, "R8 no side result one edge after load");
        @(negedge clk);
        chk({b_side_valid, m_side_valid, b_wb_valid, m_wb_valid}, 4'b1100, "R6 side only");
        chk({b_side_dst, b_side_flag, b_side_addr}, {d, taken, sx(i)}, "R6 branch side");
        chk({m_side_dst, m_side_flag, m_side_addr}, {d, (op == 4'd11), a + sx(i)},
            "R7 memory side");
    endtask

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R1: reset state
        chk({b_spc_ready, b_gen_ready, m_spc_ready, m_gen_ready}, 4'hF, "R1 ready after reset");
        chk({b_wb_valid, b_side_valid, m_wb_valid, m_side_valid}, 4'h0, "R1 outputs idle");
        rst_n = 1'b1;
        @(negedge clk);
        chk({b_spc_ready, b_gen_ready, b_wb_valid, b_side_valid}, 4'b1100, "R1 idle after release");

        // R5: every opcode over varied operands
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 6; k++) begin
                logic [15:0] a, b;
                logic [11:0] i;
                a = 16'((k * 16'h3D1B) ^ (op * 16'h0777));
                b = (k == 0) ? 16'hFFFF : 16'((k * 16'h5A53) + op);
                i = (k == 1) ? 12'h800 : (k == 2) ? 12'hFFF : 12'((k * 12'h29B) + op);
                run_gen(4'(op), 4'(op + k), a, b, i);
            end
        end

        // R6, R7: every opcode with equal and unequal sources, wrap and negative immediates
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 4; k++) begin
                logic [15:0] a, b;
                logic [11:0] i;
                a = (k == 3) ? 16'hFFF0 : 16'((op * 16'h1111) + k);
                b = (k[0]) ? a : a ^ 16'(1 << k);
                i = (k == 3) ? 12'h020 : (k == 2) ? 12'h800 : 12'((op * 12'h123) ^ k);
                run_spc(4'(op), 4'(15 - op), a, b, i);
            end
        end

        // R3, R2, R4: both slots loaded, then loads into the full slots must be ignored
        spc_op = 4'd8; spc_dst = 4'd3; spc_src1 = 16'h1234; spc_src2 = 16'h1234; spc_imm = 12'h010;
        gen_op = 4'd0; gen_dst = 4'd7; gen_src1 = 16'h0100; gen_src2 = 16'h0023; gen_imm = 12'h0;
        spc_load = 1'b1; gen_load = 1'b1;
        @(negedge clk);
        chk({b_spc_ready, b_gen_ready}, 2'b00, "R2 both slots full");
        spc_op = 4'd9; spc_dst = 4'd9; spc_src1 = 16'h0; spc_src2 = 16'h1; spc_imm = 12'h7FF;
        gen_op = 4'd1; gen_dst = 4'd2; gen_src1 = 16'h0; gen_src2 = 16'h5;
        @(negedge clk);
        chk({b_side_valid, b_wb_valid}, 2'b10, "R3 special result first");
        chk({b_side_dst, b_side_flag, b_side_addr}, {4'd3, 1'b1, 16'h0010}, "R2 special kept first op");
        chk({m_side_dst, m_side_flag, m_side_addr}, {4'd3, 1'b0, 16'h1244}, "R7 memory first op");
        chk({b_spc_ready, b_gen_ready}, 2'b10, "R4 special slot freed");
        spc_load = 1'b0;
        @(negedge clk);
        gen_load = 1'b0;
        chk({b_side_valid, b_wb_valid}, 2'b01, "R3 general result second");
        chk({b_wb_dst, b_wb_data}, {4'd7, 16'h0123}, "R2 general kept first op");
        @(negedge clk);
        chk({b_side_valid, b_wb_valid, m_side_valid, m_wb_valid}, 4'h0, "R2 ignored loads left no result");
        chk({b_spc_ready, b_gen_ready}, 2'b11, "R4 both slots empty");
        @(negedge clk);
        chk({b_side_valid, b_wb_valid}, 2'b00, "R4 one output cycle per op");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule